// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block sits between instruction decode and the data-memory port of a 64-bit fixed-point core. For every decoded load or store it forms the effective address from a base register value, a displacement (either a sign-extended immediate or a second register value) and, for PC-relative prefixed forms, the current instruction address. In the same step it decides whether the encoded form is legal. A legal operation becomes a memory request one cycle later. An illegal one raises an invalid-form flag in that cycle instead, with no request.

Update forms also get a writeback of the effective address to the base register. This writeback is presented in the same cycle as the request. A separate path takes data returned by memory and widens it to 64 bits, with zero or sign extension chosen by access size and signedness. That result is registered one cycle after the return. The register file, the memory system and any byte swapping lie outside the block.

Top module: `lsea_unit`

## Requirements
- R1: For a legal operation, `req_addr` equals B + D modulo 2^64. B is zero when `op_ra` is 0 and `ra_value` otherwise. D is `rb_value` when `op_use_rb` is 1 and the sign-extended `op_imm` otherwise. `req_valid` rises exactly one cycle after `op_valid`.
- R2: An update operation (`op_update`=1) with `op_ra`=0 raises `invalid` and produces no request and no writeback.
- R3: An update load whose `op_ra` equals `op_rt` is invalid. An update store with `op_ra` equal to `op_rt` is legal.
- R4: A legal update operation asserts `wb_valid` in the same cycle as `req_valid`, with `wb_reg`=`op_ra` and `wb_data` equal to the request address. Non-update operations never assert `wb_valid`.
- R5: When `op_narrow` is 1, bits 63:32 of the address are zero and bits 31:0 are those of the full sum.
- R6: When `op_prefixed`=1 and `op_rel`=1, `cia` is added to the displacement, and a nonzero `op_ra` makes the form invalid. `op_rel` has no effect when `op_prefixed`=0.
- R7: Size codes are 0 byte, 1 halfword, 2 word and 3 doubleword. `op_sext`=1 is legal only on halfword and word loads; with a byte size, a doubleword size or a store it is invalid. `req_sext` is 1 exactly for legal signed loads, and `req_size` and `req_store` echo the operation.
- R8: With parameter IS64=0, doubleword operations and signed word loads are invalid.
- R9: `invalid` and `req_valid` are never high together. Exactly one of them is high in the cycle after each `op_valid`, and neither is high in a cycle not preceded by `op_valid`.
- R10: One cycle after `ld_valid`, `ext_valid` is high and `ext_data` holds `ld_data` extended from its low byte, halfword or word (per `ld_size`). Halfword and word are sign-extended when `ld_sext`=1 and zero-extended otherwise. Byte is always zero-extended, and doubleword passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Decoded operation present |
| op_rt | input | REG_IDX_W | Target/source data register index |
| op_ra | input | REG_IDX_W | Base register index (0 means constant zero) |
| ra_value | input | 64 | Contents of the base register |
| rb_value | input | 64 | Contents of the index register |
| op_imm | input | IMM_W | Signed immediate displacement |
| op_use_rb | input | 1 | 1: displacement is `rb_value`, 0: immediate |
| op_update | input | 1 | Update form: write address back to base |
| op_store | input | 1 | 1 store, 0 load |
| op_prefixed | input | 1 | Prefixed encoding |
| op_rel | input | 1 | PC-relative bit of a prefixed encoding |
| cia | input | 64 | Address of the current instruction |
| op_narrow | input | 1 | 32-bit addressing mode |
| op_size | input | 2 | Access size code |
| op_sext | input | 1 | Signed (algebraic) load |
| req_valid | output | 1 | Memory request |
| req_addr | output | 64 | Effective address |
| req_size | output | 2 | Access size code |
| req_store | output | 1 | Request is a store |
| req_sext | output | 1 | Returned data must be sign-extended |
| invalid | output | 1 | Illegal instruction form |
| wb_valid | output | 1 | Base-register writeback |
| wb_reg | output | REG_IDX_W | Writeback register index |
| wb_data | output | 64 | Writeback value |
| ld_valid | input | 1 | Load data returned |
| ld_data | input | 64 | Raw returned data |
| ld_size | input | 2 | Size code of returned data |
| ld_sext | input | 1 | Sign-extend returned data |
| ext_valid | output | 1 | Extended data valid |
| ext_data | output | 64 | Extended load data |

## Verification
There is one register stage between decode and every output, so a fault in the legality terms, the base or displacement selection or the relative-address addition shows up at the ports on the edge that follows the operation. It appears as a misplaced `invalid`, a missing request, or a wrong address or writeback value. A sweep over every combination of form flags, size, signedness and mode, with small register indices so that zero-base and overlap cases occur often, exposes such faults operation by operation. The bench also confirms that the request disappears the cycle after `op_valid` drops, which catches faults in the handshake.

// File: rtl/lsea_pkg.sv
package lsea_pkg;

  localparam int unsigned ADDR_W = 64;
  localparam int unsigned NARROW_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // Wrap-around address sum of base, displacement and relative offset.
  function automatic logic [ADDR_W-1:0] ea_sum(
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] disp,
    input logic [ADDR_W-1:0] rel_ofs
  );
    return base + disp + rel_ofs;
  endfunction

  // Clears the upper part of an address in 32-bit mode.
  function automatic logic [ADDR_W-1:0] fold_narrow(
    input logic [ADDR_W-1:0] ea,
    input logic              narrow
  );
    logic [ADDR_W-1:0] r;
    r = ea;
    if (narrow) r[ADDR_W-1:NARROW_W] = '0;
    return r;
  endfunction

  // Widens returned data according to size and signedness.
  function automatic logic [ADDR_W-1:0] load_extend(
    input logic [ADDR_W-1:0] d,
    input acc_size_e         sz,
    input logic              sx
  );
    logic [ADDR_W-1:0] r;
    unique case (sz)
      SZ_BYTE:  r = {{(ADDR_W-8){1'b0}}, d[7:0]};
      SZ_HALF:  r = {{(ADDR_W-16){sx & d[15]}}, d[15:0]};
      SZ_WORD:  r = {{(ADDR_W-32){sx & d[31]}}, d[31:0]};
      default:  r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsea_check.sv
module lsea_check
  import lsea_pkg::*;
#(
  parameter int unsigned REG_IDX_W = 5,
  parameter bit          IS64      = 1'b1
) (
  input  logic [REG_IDX_W-1:0] rt,
  input  logic [REG_IDX_W-1:0] ra,
  input  logic                 update,
  input  logic                 store,
  input  logic                 prefixed,
  input  logic                 rel,
  input  acc_size_e            size,
  input  logic                 sext,
  output logic                 bad_upd_zero,
  output logic                 bad_upd_overlap,
  output logic                 bad_rel_base,
  output logic                 bad_signed,
  output logic                 bad_width,
  output logic                 form_bad
);

  logic ra_is_zero;
  logic ra_eq_rt;

  assign ra_is_zero = (ra == '0);
  assign ra_eq_rt   = (ra == rt);

  always_comb begin
    bad_upd_zero    = update & ra_is_zero;
    bad_upd_overlap = update & ~store & ra_eq_rt;
    bad_rel_base    = prefixed & rel & ~ra_is_zero;
    bad_signed      = sext & (store | (size == SZ_BYTE) | (size == SZ_DWORD));
  end

  generate
    if (IS64) begin : g_wide
      assign bad_width = 1'b0;
    end else begin : g_narrow_impl
      assign bad_width = (size == SZ_DWORD) | ((size == SZ_WORD) & sext);
    end
  endgenerate

  assign form_bad = bad_upd_zero | bad_upd_overlap | bad_rel_base
                  | bad_signed | bad_width;

endmodule

// File: rtl/lsea_agen.sv
module lsea_agen
  import lsea_pkg::*;
#(
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned IMM_W     = 34
) (
  input  logic [REG_IDX_W-1:0] ra,
  input  logic [ADDR_W-1:0]    ra_value,
  input  logic [ADDR_W-1:0]    rb_value,
  input  logic [IMM_W-1:0]     imm,
  input  logic                 use_rb,
  input  logic                 prefixed,
  input  logic                 rel,
  input  logic [ADDR_W-1:0]    cia,
  input  logic                 narrow,
  output logic [ADDR_W-1:0]    base_sel,
  output logic [ADDR_W-1:0]    disp_sel,
  output logic [ADDR_W-1:0]    ea
);

  localparam int unsigned EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_wide;
  logic [ADDR_W-1:0] rel_ofs;
  logic [ADDR_W-1:0] ea_full;

  assign imm_wide = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign base_sel = (ra == '0) ? '0 : ra_value;
  assign disp_sel = use_rb ? rb_value : imm_wide;
  assign rel_ofs  = (prefixed & rel) ? cia : '0;
  assign ea_full  = ea_sum(base_sel, disp_sel, rel_ofs);
  assign ea       = fold_narrow(ea_full, narrow);

endmodule

// File: rtl/lsea_extend.sv
module lsea_extend
  import lsea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_data,
  input  logic [1:0]        ld_size,
  input  logic              ld_sext,
  output logic              ext_valid,
  output logic [ADDR_W-1:0] ext_data
);

  logic [ADDR_W-1:0] ext_next;

  assign ext_next = load_extend(ld_data, acc_size_e'(ld_size), ld_sext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_valid <= 1'b0;
      ext_data  <= '0;
    end else begin
      ext_valid <= ld_valid;
      if (ld_valid) ext_data <= ext_next;
    end
  end

  AST_EXT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ext_valid); // R10
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> $stable(ext_data)); // R10

endmodule

// File: rtl/lsea_unit.sv
module lsea_unit
  import lsea_pkg::*;
#(
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned IMM_W     = 34,
  parameter bit          IS64      = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [REG_IDX_W-1:0] op_rt,
  input  logic [REG_IDX_W-1:0] op_ra,
  input  logic [63:0]          ra_value,
  input  logic [63:0]          rb_value,
  input  logic [IMM_W-1:0]     op_imm,
  input  logic                 op_use_rb,
  input  logic                 op_update,
  input  logic                 op_store,
  input  logic                 op_prefixed,
  input  logic                 op_rel,
  input  logic [63:0]          cia,
  input  logic                 op_narrow,
  input  logic [1:0]           op_size,
  input  logic                 op_sext,
  output logic                 req_valid,
  output logic [63:0]          req_addr,
  output logic [1:0]           req_size,
  output logic                 req_store,
  output logic                 req_sext,
  output logic                 invalid,
  output logic                 wb_valid,
  output logic [REG_IDX_W-1:0] wb_reg,
  output logic [63:0]          wb_data,
  input  logic                 ld_valid,
  input  logic [63:0]          ld_data,
  input  logic [1:0]           ld_size,
  input  logic                 ld_sext,
  output logic                 ext_valid,
  output logic [63:0]          ext_data
);

  logic bad_upd_zero;
  logic bad_upd_overlap;
  logic bad_rel_base;
  logic bad_signed;
  logic bad_width;
  logic form_bad;
  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] disp_sel;
  logic [ADDR_W-1:0] ea;
  logic issue_ok;
  logic issue_bad;

  lsea_check #(
    .REG_IDX_W(REG_IDX_W),
    .IS64     (IS64)
  ) u_check (
    .rt             (op_rt),
    .ra             (op_ra),
    .update         (op_update),
    .store          (op_store),
    .prefixed       (op_prefixed),
    .rel            (op_rel),
    .size           (acc_size_e'(op_size)),
    .sext           (op_sext),
    .bad_upd_zero   (bad_upd_zero),
    .bad_upd_overlap(bad_upd_overlap),
    .bad_rel_base   (bad_rel_base),
    .bad_signed     (bad_signed),
    .bad_width      (bad_width),
    .form_bad       (form_bad)
  );

  lsea_agen #(
    .REG_IDX_W(REG_IDX_W),
    .IMM_W    (IMM_W)
  ) u_agen (
    .ra      (op_ra),
    .ra_value(ra_value),
    .rb_value(rb_value),
    .imm     (op_imm),
    .use_rb  (op_use_rb),
    .prefixed(op_prefixed),
    .rel     (op_rel),
    .cia     (cia),
    .narrow  (op_narrow),
    .base_sel(base_sel),
    .disp_sel(disp_sel),
    .ea      (ea)
  );

  lsea_extend u_extend (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_data  (ld_data),
    .ld_size  (ld_size),
    .ld_sext  (ld_sext),
    .ext_valid(ext_valid),
    .ext_data (ext_data)
  );

  assign issue_ok  = op_valid & ~form_bad;
  assign issue_bad = op_valid & form_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_size  <= '0;
      req_store <= 1'b0;
      req_sext  <= 1'b0;
      invalid   <= 1'b0;
      wb_valid  <= 1'b0;
      wb_reg    <= '0;
      wb_data   <= '0;
    end else begin
      req_valid <= issue_ok;
      invalid   <= issue_bad;
      wb_valid  <= issue_ok & op_update;
      if (issue_ok) begin
        req_addr  <= ea;
        req_size  <= op_size;
        req_store <= op_store;
        req_sext  <= op_sext & ~op_store;
        wb_reg    <= op_ra;
        wb_data   <= ea;
      end
    end
  end

  AST_REQ_XOR_INV: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && invalid)); // R9
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (req_valid || invalid)); // R9
  AST_NO_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid || invalid) |-> $past(op_valid)); // R9
  AST_WB_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (req_valid && wb_data == req_addr)); // R4
  AST_WB_BASE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_reg != '0)); // R2
  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(op_narrow)) |-> (req_addr[63:32] == 32'd0)); // R5
  AST_SEXT_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sext) |-> (!req_store && (req_size == 2'd1 || req_size == 2'd2))); // R7

endmodule

// File: tb/sim_lsea_unit.sv
`timescale 1ns/1ps
module sim_lsea_unit;

  localparam int RW = 5;
  localparam int IW = 34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [RW-1:0] op_rt = '0;
  logic [RW-1:0] op_ra = '0;
  logic [63:0]   ra_value = '0;
  logic [63:0]   rb_value = '0;
  logic [IW-1:0] op_imm = '0;
  logic          op_use_rb = 1'b0;
  logic          op_update = 1'b0;
  logic          op_store = 1'b0;
  logic          op_prefixed = 1'b0;
  logic          op_rel = 1'b0;
  logic [63:0]   cia = '0;
  logic          op_narrow = 1'b0;
  logic [1:0]    op_size = '0;
  logic          op_sext = 1'b0;
  logic          ld_valid = 1'b0;
  logic [63:0]   ld_data = '0;
  logic [1:0]    ld_size = '0;
  logic          ld_sext = 1'b0;

  logic          req_valid, req_store, req_sext, invalid, wb_valid, ext_valid;
  logic [63:0]   req_addr, wb_data, ext_data;
  logic [1:0]    req_size;
  logic [RW-1:0] wb_reg;

  logic          n_req_valid, n_req_store, n_req_sext, n_invalid, n_wb_valid, n_ext_valid;
  logic [63:0]   n_req_addr, n_wb_data, n_ext_data;
  logic [1:0]    n_req_size;
  logic [RW-1:0] n_wb_reg;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  lsea_unit #(.REG_IDX_W(RW), .IMM_W(IW), .IS64(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_rt(op_rt), .op_ra(op_ra),
    .ra_value(ra_value), .rb_value(rb_value), .op_imm(op_imm), .op_use_rb(op_use_rb),
    .op_update(op_update), .op_store(op_store), .op_prefixed(op_prefixed),
    .op_rel(op_rel), .cia(cia), .op_narrow(op_narrow), .op_size(op_size),
    .op_sext(op_sext), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_store(req_store), .req_sext(req_sext),
    .invalid(invalid), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_size(ld_size), .ld_sext(ld_sext),
    .ext_valid(ext_valid), .ext_data(ext_data));

  lsea_unit #(.REG_IDX_W(RW), .IMM_W(IW), .IS64(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_rt(op_rt), .op_ra(op_ra),
    .ra_value(ra_value), .rb_value(rb_value), .op_imm(op_imm), .op_use_rb(op_use_rb),
    .op_update(op_update), .op_store(op_store), .op_prefixed(op_prefixed),
    .op_rel(op_rel), .cia(cia), .op_narrow(op_narrow), .op_size(op_size),
    .op_sext(op_sext), .req_valid(n_req_valid), .req_addr(n_req_addr),
    .req_size(n_req_size), .req_store(n_req_store), .req_sext(n_req_sext),
    .invalid(n_invalid), .wb_valid(n_wb_valid), .wb_reg(n_wb_reg), .wb_data(n_wb_data),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_size(ld_size), .ld_sext(ld_sext),
    .ext_valid(n_ext_valid), .ext_data(n_ext_data));

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model of form legality.
  function automatic bit model_bad(int ra, int rt, bit upd, bit st, int sz, bit sg,
                                   bit pf, bit r, bit wide);
    bit b;
    b = 0;
    if (upd && ra == 0) b = 1;
    if (upd && !st && ra == rt) b = 1;
    if (pf && r && ra != 0) b = 1;
    if (sg && (st || sz == 0 || sz == 3)) b = 1;
    if (!wide && (sz == 3 || (sz == 2 && sg))) b = 1;
    return b;
  endfunction

  function automatic string bad_tag(int ra, int rt, bit upd, bit st, bit pf, bit r);
    if (upd && ra == 0) return "R2";
    if (upd && ra == rt) return "R3";
    if (pf && r && ra != 0) return "R6";
    return "R7";
  endfunction

  function automatic logic [63:0] model_ext(logic [63:0] d, int sz, bit sx);
    logic [63:0] m;
    case (sz)
      0: m = d & 64'hFF;
      1: m = (sx && d[15]) ? (d | 64'hFFFF_FFFF_FFFF_0000) : (d & 64'hFFFF);
      2: m = (sx && d[31]) ? (d | 64'hFFFF_FFFF_0000_0000) : (d & 64'hFFFF_FFFF);
      default: m = d;
    endcase
    return m;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [63:0] imm_tab [4];
    logic [63:0] exp_ea, base, disp;
    bit bad, bad32;
    string tag;
    imm_tab[0] = 64'hFFFF_FFFF_FFFF_FFF8;
    imm_tab[1] = 64'h0000_0000_0000_0040;
    imm_tab[2] = 64'hFFFF_FFFE_0000_0000;
    imm_tab[3] = 64'h0000_0001_FFFF_FFFF;

    repeat (3) @(negedge clk);
    check(req_valid == 0 && invalid == 0 && wb_valid == 0 && ext_valid == 0,
          "R9 reset", {60'd0, req_valid, invalid, wb_valid, ext_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int ra = 0; ra < 4; ra++)
    for (int rt = 0; rt < 4; rt++)
    for (int upd = 0; upd < 2; upd++)
    for (int st = 0; st < 2; st++)
    for (int sz = 0; sz < 4; sz++)
    for (int sg = 0; sg < 2; sg++)
    for (int urb = 0; urb < 2; urb++)
    for (int pf = 0; pf < 2; pf++)
    for (int r = 0; r < 2; r++)
    for (int nw = 0; nw < 2; nw++) begin
      op_ra = RW'(ra); op_rt = RW'(rt);
      op_update = upd[0]; op_store = st[0]; op_size = sz[1:0]; op_sext = sg[0];
      op_use_rb = urb[0]; op_prefixed = pf[0]; op_rel = r[0]; op_narrow = nw[0];
      ra_value = 64'h8000_1234_FFFF_FF00 + 64'(ra * 8) + 64'(rt * 3);
      rb_value = 64'h0000_0000_8000_0010 + 64'(sz * 16);
      op_imm   = imm_tab[(ra + rt + sz) % 4][IW-1:0];
      cia      = 64'h0000_0001_FFFF_FFF0 + 64'(st * 4);
      op_valid = 1'b1;
      base = (ra == 0) ? 64'd0 : ra_value;
      disp = urb ? rb_value : imm_tab[(ra + rt + sz) % 4];
      exp_ea = base + disp + ((pf && r) ? cia : 64'd0);
      if (nw) exp_ea = exp_ea & 64'h0000_0000_FFFF_FFFF;
      bad   = model_bad(ra, rt, upd[0], st[0], sz, sg[0], pf[0], r[0], 1'b1);
      bad32 = model_bad(ra, rt, upd[0], st[0], sz, sg[0], pf[0], r[0], 1'b0);
      @(negedge clk);
      op_valid = 1'b0;
      tag = bad ? bad_tag(ra, rt, upd[0], st[0], pf[0], r[0])
                : ((upd && ra == rt) ? "R3 store overlap" : "R9");
      check(invalid == bad && req_valid == !bad, tag,
            {62'd0, invalid, req_valid}, {62'd0, bad, !bad});
      if (bad) begin
        check(wb_valid == 0, "R2 no writeback on invalid", {63'd0, wb_valid}, 64'd0);
      end else begin
        tag = nw ? "R5" : ((pf && r) ? "R6" : (r ? "R6 rel ignored" : "R1"));
        check(req_addr == exp_ea, tag, req_addr, exp_ea);
        check(req_size == sz[1:0] && req_store == st[0] && req_sext == (sg && !st),
              "R7 request attrs", {60'd0, req_size, req_store, req_sext},
              {60'd0, sz[1:0], st[0], sg[0] & ~st[0]});
        check(wb_valid == upd[0] && (!upd || (wb_reg == RW'(ra) && wb_data == exp_ea)),
              "R4", wb_data, upd ? exp_ea : 64'd0);
      end
      check(n_invalid == bad32 && n_req_valid == !bad32, "R8 narrow implementation",
            {62'd0, n_invalid, n_req_valid}, {62'd0, bad32, !bad32});
      @(negedge clk);
      check(req_valid == 0 && invalid == 0, "R9 idle",
            {62'd0, req_valid, invalid}, 64'd0);
    end

    for (int sz = 0; sz < 4; sz++)
    for (int sx = 0; sx < 2; sx++)
    for (int p = 0; p < 4; p++) begin
      logic [63:0] d, e;
      case (p)
        0: d = 64'h1234_5678_9ABC_DEF0;
        1: d = 64'hFEDC_BA98_7654_3210;
        2: d = 64'h0000_0000_8000_8080;
        default: d = 64'hFFFF_FFFF_7FFF_7F7F;
      endcase
      ld_data = d; ld_size = sz[1:0]; ld_sext = sx[0]; ld_valid = 1'b1;
      e = model_ext(d, sz, sx[0]);
      @(negedge clk);
      ld_valid = 1'b0;
      check(ext_valid == 1 && ext_data == e, "R10 load extend", ext_data, e);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule